// File: doc/BRIEF.md
# Packet completion status and interrupt latch

This block keeps the completion state of a packet modem. The receiver reports each finished packet with a one-cycle pulse on one of two lines, one for a packet whose CRC passed (good) and one for a packet whose CRC failed (bad). The transmitter pulses a third line when a transmission has finished. Each pulse sets a sticky flag. The flag stays set until the controlling software clears it.

Each receive flag sets only while its own enable input is high. Each receive flag also drives an interrupt output directly. The transmit-done flag has no enable. Software clears a flag by raising its clear input and later lowering it. While the clear is high it acts as a held reset on that flag, and it overrides any event that arrives in the same cycle.

The block presents the receive flags as a two-bit status word: bit 0 is good and bit 1 is bad. The transmit-done flag is bit 0 of a status word of its own. CRC computation and register access are outside the block.

Top module: `pkt_done_irq`

## Requirements
- R1: After the active-low reset, `rx_status_o`, `tx_status_o`, `irq_good_o` and `irq_bad_o` are all 0.
- R2: If a good event (`rx_evt_i[0]`) arrives while `rx_en_i[0]` is 1 and `rx_clr_i[0]` is 0, `rx_status_o[0]` is 1 from the next clock edge on.
- R3: If a bad event (`rx_evt_i[1]`) arrives while `rx_en_i[1]` is 1 and `rx_clr_i[1]` is 0, `rx_status_o[1]` is 1 from the next clock edge on.
- R4: A receive event that arrives while its enable is 0 leaves its status bit unchanged.
- R5: A set flag stays set, with no further events and with its enable dropped, until that flag's clear is raised.
- R6: While a clear input is 1, its flag is 0 one edge later and stays 0, even when events arrive during that time.
- R7: After a clear input returns to 0, a new qualifying event sets the flag again.
- R8: `tx_done_evt_i` sets `tx_status_o` on the next edge with no enable. `tx_done_clr_i` clears it with the same held, overriding behaviour as R6.
- R9: `irq_good_o` always equals `rx_status_o[0]`, and `irq_bad_o` always equals `rx_status_o[1]`.
- R10: Events, enables and clears for one flag never change either of the other two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_evt_i | input | 2 | Receive completion pulses: bit 0 is CRC pass, bit 1 is CRC fail |
| rx_en_i | input | 2 | Set enable for each receive flag |
| rx_clr_i | input | 2 | Held clear for each receive flag |
| tx_done_evt_i | input | 1 | Transmission-complete pulse |
| tx_done_clr_i | input | 1 | Held clear for the transmit-done flag |
| rx_status_o | output | 2 | Receive flags: bit 0 is good, bit 1 is bad |
| tx_status_o | output | 1 | Transmit-done flag |
| irq_good_o | output | 1 | Good-packet interrupt |
| irq_bad_o | output | 1 | Bad-packet interrupt |

## Verification
The bench puts the three flags into each of their eight joint states. From every state it applies all 256 combinations of events, enables and clears for one cycle, and compares every output with an arithmetic model.

Several faults would show up in this sweep:
- If the enable is ignored, a status bit rises on an event that has its enable low.
- If the event is given priority over the clear, a flag rises while its clear is held.
- If the flags are not sticky, a set flag drops once its enable falls.
- If an index is wired crosswise, an input for one flag changes a neighbouring flag.

Directed sequences also check that a flag can be set again after its clear is released.

// File: rtl/pkt_done_pkg.sv
package pkt_done_pkg;
  localparam int unsigned RX_KINDS = 2;
  typedef enum int unsigned {
    RX_GOOD = 0,
    RX_BAD  = 1
  } rx_kind_e;
endpackage

// File: rtl/pkt_done_flag.sv
module pkt_done_flag #(
  parameter bit GATED = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic en_i,
  input  logic clr_i,
  output logic flag_o
);
  logic arm;
  logic flag_q, flag_d;

  assign arm = GATED ? en_i : 1'b1;

  // held clear dominates any event in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (clr_i)            flag_d = 1'b0;
    else if (evt_i && arm) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pkt_done_irq.sv
module pkt_done_irq
  import pkt_done_pkg::*;
#(
  parameter int unsigned NRX = RX_KINDS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NRX-1:0] rx_evt_i,
  input  logic [NRX-1:0] rx_en_i,
  input  logic [NRX-1:0] rx_clr_i,
  input  logic           tx_done_evt_i,
  input  logic           tx_done_clr_i,
  output logic [NRX-1:0] rx_status_o,
  output logic           tx_status_o,
  output logic           irq_good_o,
  output logic           irq_bad_o
);
  logic [NRX-1:0] rx_flag;

  for (genvar k = 0; k < NRX; k++) begin : g_rx
    pkt_done_flag #(.GATED(1'b1)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (rx_evt_i[k]),
      .en_i   (rx_en_i[k]),
      .clr_i  (rx_clr_i[k]),
      .flag_o (rx_flag[k])
    );
  end

  pkt_done_flag #(.GATED(1'b0)) u_tx_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (tx_done_evt_i),
    .en_i   (1'b1),
    .clr_i  (tx_done_clr_i),
    .flag_o (tx_status_o)
  );

  assign rx_status_o = rx_flag;
  assign irq_good_o  = rx_flag[RX_GOOD];
  assign irq_bad_o   = rx_flag[RX_BAD];
endmodule

// File: rtl/pkt_done_irq_chk.sv
module pkt_done_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] rx_evt_i,
  input logic [1:0] rx_en_i,
  input logic [1:0] rx_clr_i,
  input logic       tx_done_evt_i,
  input logic       tx_done_clr_i,
  input logic [1:0] rx_status_o,
  input logic       tx_status_o
);
  // R2
  good_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i[0] && rx_en_i[0] && !rx_clr_i[0] |=> rx_status_o[0]);
  // R3
  bad_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i[1] && rx_en_i[1] && !rx_clr_i[1] |=> rx_status_o[1]);
  // R4
  good_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_clr_i[0] && !(rx_evt_i[0] && rx_en_i[0]) |=> $stable(rx_status_o[0]));
  // R4
  bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_clr_i[1] && !(rx_evt_i[1] && rx_en_i[1]) |=> $stable(rx_status_o[1]));
  // R6
  good_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr_i[0] |=> !rx_status_o[0]);
  // R6
  bad_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr_i[1] |=> !rx_status_o[1]);
  // R8
  tx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_evt_i && !tx_done_clr_i |=> tx_status_o);
  // R8
  tx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_clr_i |=> !tx_status_o);
  // R8
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_done_clr_i && !tx_done_evt_i |=> $stable(tx_status_o));
endmodule

bind pkt_done_irq pkt_done_irq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_evt_i      (rx_evt_i),
  .rx_en_i       (rx_en_i),
  .rx_clr_i      (rx_clr_i),
  .tx_done_evt_i (tx_done_evt_i),
  .tx_done_clr_i (tx_done_clr_i),
  .rx_status_o   (rx_status_o),
  .tx_status_o   (tx_status_o)
);

// File: tb/pkt_done_irq_test.sv
module pkt_done_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rx_evt = '0, rx_en = '0, rx_clr = '0;
  logic       tx_evt = 1'b0, tx_clr = 1'b0;
  logic [1:0] rx_st;
  logic       tx_st, irq_g, irq_b;
  int         checks = 0, fails = 0;

  always #10 clk = ~clk;

  pkt_done_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_evt_i(rx_evt), .rx_en_i(rx_en),
    .rx_clr_i(rx_clr), .tx_done_evt_i(tx_evt), .tx_done_clr_i(tx_clr),
    .rx_status_o(rx_st), .tx_status_o(tx_st), .irq_good_o(irq_g), .irq_bad_o(irq_b)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    rx_evt = '0; rx_en = '0; rx_clr = '0; tx_evt = 1'b0; tx_clr = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // state bits: 0 good, 1 bad, 2 tx
  task automatic force_state(input logic [2:0] st);
    idle(); rx_clr = 2'b11; tx_clr = 1'b1; step();
    idle(); rx_evt = st[1:0]; rx_en = st[1:0]; tx_evt = st[2]; step();
    idle();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step();
    chk(rx_st[0], 1'b0, "R1 good in reset");
    chk(rx_st[1], 1'b0, "R1 bad in reset");
    chk(tx_st, 1'b0, "R1 tx in reset");
    rst_n = 1'b1; step();
    chk(irq_g | irq_b, 1'b0, "R1 irq after reset");

    // R4: disabled event ignored
    rx_evt = 2'b11; step(); idle(); step();
    chk(rx_st[0], 1'b0, "R4 good disabled");
    chk(rx_st[1], 1'b0, "R4 bad disabled");

    // R2 good set
    rx_evt[0] = 1'b1; rx_en[0] = 1'b1; step(); idle();
    chk(rx_st[0], 1'b1, "R2 good set");
    chk(irq_g, 1'b1, "R9 irq_good");
    chk(rx_st[1], 1'b0, "R10 bad untouched");
    chk(tx_st, 1'b0, "R10 tx untouched");
    // R5 sticky with enable low
    step(); step(); step();
    chk(rx_st[0], 1'b1, "R5 good sticky");
    // R6 held clear beats events
    rx_clr[0] = 1'b1; rx_evt[0] = 1'b1; rx_en[0] = 1'b1; step();
    chk(rx_st[0], 1'b0, "R6 clear cycle 1");
    step();
    chk(rx_st[0], 1'b0, "R6 clear cycle 2");
    chk(irq_g, 1'b0, "R9 irq_good low");
    // R7 re-arm
    rx_clr[0] = 1'b0; step(); idle();
    chk(rx_st[0], 1'b1, "R7 good re-set");

    // R3 bad set
    rx_evt[1] = 1'b1; rx_en[1] = 1'b1; step(); idle();
    chk(rx_st[1], 1'b1, "R3 bad set");
    chk(irq_b, 1'b1, "R9 irq_bad");
    rx_clr[1] = 1'b1; step(); idle();
    chk(rx_st[1], 1'b0, "R6 bad cleared");
    chk(rx_st[0], 1'b1, "R10 good kept");

    // R8 transmit done
    tx_evt = 1'b1; step(); idle(); step();
    chk(tx_st, 1'b1, "R8 tx set sticky");
    tx_clr = 1'b1; tx_evt = 1'b1; step();
    chk(tx_st, 1'b0, "R8 tx clear wins");
    idle(); tx_evt = 1'b1; step(); idle();
    chk(tx_st, 1'b1, "R8 tx re-set");

    // sweep: every prior state x every input combination
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 256; c++) begin
        logic [2:0] st, nx;
        logic [7:0] v;
        st = 3'(s); v = 8'(c);
        force_state(st);
        chk(rx_st[0], st[0], "R5 prior good");
        rx_evt = v[1:0]; rx_en = v[3:2]; rx_clr = v[5:4]; tx_evt = v[6]; tx_clr = v[7];
        for (int k = 0; k < 2; k++)
          nx[k] = v[4+k] ? 1'b0 : ((v[k] && v[2+k]) ? 1'b1 : st[k]);
        nx[2] = v[7] ? 1'b0 : (v[6] ? 1'b1 : st[2]);
        step(); idle();
        for (int k = 0; k < 2; k++) begin
          string tag;
          if (v[4+k])                tag = "R6 sweep clear";
          else if (v[k] && v[2+k])   tag = (k == 0) ? "R2 sweep set" : "R3 sweep set";
          else if (v[k])             tag = "R4 sweep disabled";
          else                       tag = "R10 sweep hold";
          chk(rx_st[k], nx[k], tag);
        end
        chk(tx_st, nx[2], "R8 sweep tx");
        chk(irq_g, nx[0], "R9 sweep irq_good");
        chk(irq_b, nx[1], "R9 sweep irq_bad");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule